// File: doc/BRIEF.md
# Masked-Write GPIO Bank Controller

This block drives one bank of 32 general-purpose I/O pins from a simple register bus. It holds three registers for the pads: output data, direction and output enable. It also presents the synchronized pin levels through a read-only register. A pin drives its pad only when both its direction bit and its output-enable bit are 1.

The output data register has no plain write address. Software changes it through two half-word masked-write ports. Each write to one of these ports carries a 16-bit active-low write mask in the upper half and 16 data bits in the lower half. A single pin can therefore be set or cleared in one bus write, with no read-modify-write and no race against other writers of the same bank. A parameter names pins that must always stay outputs. Their direction bits read back 1 whatever software writes.

The bus is plain, without back-pressure. A write is accepted in any cycle in which `bus_wr` is high, and it takes effect on that clock edge. A read strobe `bus_rd` is always accepted. The data returns one cycle later on `bus_rdata`, qualified by `bus_rvalid`. The bus has no stall and no wait state.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset the output data and output-enable registers are 0, `pad_out` and `pad_oe` are 0, `bus_rvalid` is 0, and the direction register reads back the forced-output set (0x0000_0180 by default, pins 7 and 8).
- R2: A write to the low masked port (address 0) loads output bit i (0 to 15) from data bit i wherever mask bit 16+i is 0. Output bits whose mask bit is 1 keep their value.
- R3: A write to the high masked port (address 1) maps data bit n to pin 16+n under mask bit 16+n with the same active-low rule. Pins 0 to 15 are untouched.
- R4: A read of address 0 or 1 returns the matching 16 output bits in bits 15:0, with bits 31:16 reading 0.
- R5: The direction register (address 2) is read/write, with 1 meaning output and one bit per pin. Forced-output pins always read 1.
- R6: The output-enable register (address 3) is read/write and independent of direction. `pad_oe` is the bitwise AND of direction and output enable, and `pad_out` is the output data register.
- R7: Pin inputs pass through a two-flop synchronizer. A read of address 4 returns the synchronized levels, so a level change that is applied just before edge k is first returned by a read strobed at edge k+2.
- R8: Writes to address 4 and to unused addresses 5 to 7 change no register. Reads of unused addresses return 0.
- R9: A read strobe sampled at edge k sets `bus_rvalid` high for exactly the following cycle, with data taken from the register state before edge k. A write sampled at edge k is visible at the pads after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Per-pin output value |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
The bench attacks the mask polarity with single-bit and all-ones masks. A design that treats the mask as active high would change every pin except the addressed one. A design that ignores the mask would wipe the neighbouring pins. The high port is written with only mask bit 31 clear, which exposes a swapped or unshifted half: pin 15 or pin 0 would toggle instead of pin 31. The forced-output pins are written with 0, and writes are aimed at the read-only and unused addresses. A design that leaks such a write would show a changed direction or changed pads on readback. The synchronizer depth is probed with back-to-back reads across a pin change, so a single-flop or three-flop path returns the new level one read too early or too late.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_MLO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MHI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_DIR = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_OEN = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_PIN = 3'd4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

  // cycles since reset, saturating, so the latency check never looks before reset
  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_sync_depth_R7: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int             PIN_W      = 32,
  parameter logic [PIN_W-1:0] FORCED_OUT = 32'h0000_0180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  output logic [PIN_W-1:0]  out_q,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  oe_q
);
  localparam int HALF = PIN_W / 2;

  logic [HALF-1:0] mask_n;
  logic [HALF-1:0] wbits;
  assign mask_n = wdata[PIN_W-1:HALF];
  assign wbits  = wdata[HALF-1:0];

  // each output bit sits in one half; generate per-bit load enables
  for (genvar i = 0; i < HALF; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[i]      <= 1'b0;
        out_q[HALF+i] <= 1'b0;
      end else if (wr && !mask_n[i]) begin
        if (addr == ADR_MLO) out_q[i]      <= wbits[i];
        if (addr == ADR_MHI) out_q[HALF+i] <= wbits[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= FORCED_OUT;
      oe_q  <= '0;
    end else if (wr) begin
      if (addr == ADR_DIR) dir_q <= wdata | FORCED_OUT;
      if (addr == ADR_OEN) oe_q  <= wdata;
    end
  end

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADR_MLO) |=>
      (((out_q[HALF-1:0] ^ $past(out_q[HALF-1:0])) & $past(mask_n)) == '0));
  assert_mask_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADR_MLO) |=>
      ((out_q[HALF-1:0] & ~$past(mask_n)) == ($past(wbits) & ~$past(mask_n))));
  assert_hi_port_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADR_MHI) |=>
      ((out_q[HALF-1:0] == $past(out_q[HALF-1:0])) &&
       ((out_q[PIN_W-1:HALF] & ~$past(mask_n)) == ($past(wbits) & ~$past(mask_n)))));
  assert_forced_dir_R5: assert property (@(posedge clk) disable iff (rst)
    ((dir_q & FORCED_OUT) == FORCED_OUT));
  assert_ro_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && addr >= ADR_PIN) |=> ($stable(out_q) && $stable(dir_q) && $stable(oe_q)));
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_bank_pkg::*;
#(
  parameter int               PIN_W      = 32,
  parameter logic [PIN_W-1:0] FORCED_OUT = 32'h0000_0180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PIN_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [PIN_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe
);
  localparam int HALF = PIN_W / 2;

  logic [PIN_W-1:0] out_q, dir_q, oe_q, lvl_q, rd_mux;

  gpio_bank_regs #(.PIN_W(PIN_W), .FORCED_OUT(FORCED_OUT)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .out_q(out_q), .dir_q(dir_q), .oe_q(oe_q)
  );

  gpio_in_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(lvl_q)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q & oe_q;

  always_comb begin
    unique case (bus_addr)
      ADR_MLO: rd_mux = {{HALF{1'b0}}, out_q[HALF-1:0]};
      ADR_MHI: rd_mux = {{HALF{1'b0}}, out_q[PIN_W-1:HALF]};
      ADR_DIR: rd_mux = dir_q;
      ADR_OEN: rd_mux = oe_q;
      ADR_PIN: rd_mux = lvl_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assert_rvalid_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  assert_half_read_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr <= ADR_MHI) |=> (bus_rdata[PIN_W-1:HALF] == '0));
  assert_pad_oe_R6: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & ~dir_q) == '0) && ((pad_oe & ~oe_q) == '0));
endmodule

// File: tb/gpio_mask_bank_test.sv
module gpio_mask_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gpio_mask_bank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected rvalid actual=%08h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_up();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 reads missing actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
    rd(3'd2, 32'h0000_0180, "R1 dir reset");
    rd(3'd3, 32'h0, "R1 oe reset");
    rd(3'd0, 32'h0, "R1 out reset");
    @(negedge clk);
    check("R9 rvalid idle", {31'h0, bus_rvalid}, 32'h0);
    // R5 direction and forced pins
    wr(3'd2, 32'h0);
    rd(3'd2, 32'h0000_0180, "R5 forced pins stay out");
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, 32'hFFFF_FFFF, "R5 dir all out");
    // R6 output enable independent, pad_oe = dir & oe
    wr(3'd3, 32'h0000_FFFF);
    check("R6 pad_oe full dir", pad_oe, 32'h0000_FFFF);
    wr(3'd2, 32'h0000_00F0);
    check("R6 pad_oe and", pad_oe, 32'h0000_01F0);
    rd(3'd3, 32'h0000_FFFF, "R6 oe unchanged by dir");
    // R2 low masked port
    wr(3'd0, {16'h0000, 16'hA5C3});
    check("R2 load low", pad_out, 32'h0000_A5C3);
    wr(3'd0, {16'hFFFE, 16'h0000});
    check("R2 single pin clear", pad_out, 32'h0000_A5C2);
    wr(3'd0, {16'hFFFF, 16'h0000});
    check("R2 full mask holds", pad_out, 32'h0000_A5C2);
    rd(3'd0, 32'h0000_A5C2, "R4 low half read");
    // R3 high masked port
    wr(3'd1, {16'h7FFF, 16'hFFFF});
    check("R3 pin31 only", pad_out, 32'h8000_A5C2);
    wr(3'd1, {16'h0000, 16'h1234});
    check("R3 high load", pad_out, 32'h1234_A5C2);
    rd(3'd1, 32'h0000_1234, "R4 high half read");
    // R8 writes to read-only and unused addresses
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    check("R8 pad_out after ro write", pad_out, 32'h1234_A5C2);
    check("R8 pad_oe after ro write", pad_oe, 32'h0000_01F0);
    rd(3'd2, 32'h0000_01F0, "R8 dir unchanged");
    rd(3'd3, 32'h0000_FFFF, "R8 oe unchanged");
    rd(3'd6, 32'h0, "R8 unused reads zero");
    // R7 synchronizer depth
    pad_in = 32'h0F0F_0F0F;
    repeat (3) @(negedge clk);
    pad_in = 32'h1357_9BDF;
    rd(3'd4, 32'h0F0F_0F0F, "R7 edge+0 old");
    rd(3'd4, 32'h0F0F_0F0F, "R7 edge+1 old");
    rd(3'd4, 32'h1357_9BDF, "R7 edge+2 new");
    // R9 read in same cycle as write returns pre-write state
    bus_addr = 3'd0; bus_wdata = {16'h0000, 16'hFFFF};
    bus_wr = 1'b1; bus_rd = 1'b1;
    exp_q.push_back(32'h0000_A5C2); tag_q.push_back("R9 read before write");
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9 write visible next edge", pad_out, 32'h1234_FFFF);
    rd(3'd0, 32'h0000_FFFF, "R9 read after write");
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule